// File: doc/BRIEF.md
# Ping-Pong Partitioned Buffer Writer

This block takes a stream of disk words and writes them into a pair of SRAM banks used as a ping-pong buffer. One bank is filled while the read side empties the other. Inside the bank being filled, the block spreads consecutive words across a fixed set of equal channel partitions. Word 0 goes to offset 0 of partition 0, word 1 to offset 0 of partition 1, and so on. Only after every partition has received a word does the offset advance. Each channel's data therefore lands in its own contiguous region, ready for a partition-ordered read-out.

A full bank takes exactly one transfer's worth of words. When a bank is full, the writer needs the other bank to be free before it can continue. If the read side has already released that bank, the roles swap with no lost cycle. If not, the block lowers its ready output and holds the incoming word until a drained pulse arrives. It then swaps banks and restarts addressing at zero. Write enables, addresses and data come out per bank in the same cycle a word is accepted, so they can drive the two SRAM controllers directly.

Top module: `ppw_writer`

## Requirements
- R1: In the first cycle after synchronous reset, the bank flag is 0, `in_ready` is 1, and the first accepted word is written at address 0. The bank that is not being written counts as already free.
- R2: At most one bit of `wr_en` is high. Bit 0 (the first bank) may be high only while `bank_sel` is 0, and bit 1 (the second bank) only while `bank_sel` is 1.
- R3: The k-th word accepted into a bank (counting from 0) is written at address (k mod NUM_PART)·PART_WORDS + (k div NUM_PART). The partition index advances fastest; the offset advances once per sweep of all partitions.
- R4: A word is written in the same cycle it is accepted. Acceptance means `in_valid` and `in_ready` are both high. `in_data` appears unchanged on the selected bank's data lane.
- R5: When the NUM_PART·PART_WORDS-th word of a bank is accepted and the other bank is free (or `drained` is high in that cycle), `bank_sel` toggles on the next cycle and `in_ready` stays high.
- R6: When a bank fills and the other bank is not free, `in_ready` goes low on the next cycle. It stays low, with no write, until `drained` is seen. The held word is not lost.
- R7: A `drained` pulse while stalled toggles `bank_sel` and raises `in_ready` on the next cycle. The next word goes to address 0 of the new bank.
- R8: A `drained` pulse while a bank is still filling marks the other bank free for one later swap only. Further pulses before that swap add nothing, so the swap after that still waits for a fresh pulse.
- R9: Cycles with `in_valid` low write nothing and do not advance the address sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming word is present |
| in_data | input | DATA_W | Incoming word |
| in_ready | output | 1 | Writer can accept a word this cycle |
| drained | input | 1 | One-cycle pulse: read side has emptied the bank not being written |
| bank_sel | output | 1 | Bank currently being written (0 = first, 1 = second) |
| wr_en | output | 2 | Per-bank write enable |
| wr_addr | output | 2 x ADDR_W | Per-bank write address |
| wr_data | output | 2 x DATA_W | Per-bank write data (zero when not enabled) |

## Verification
The bound checker enforces the following on every cycle:
- the one-hot write enables, and their match with the bank flag;
- the absence of writes while stalled or idle, and the address range;
- that a stall persists until a drained pulse, and that every bank change follows either a final write or a drained pulse.

The exact interleaved address order, the single-credit handling of repeated drained pulses, and the timing of a stall after the second fill are shown only by the bench. The bench drives the block with its behavioural model through back-to-back streams, gapped streams, early and repeated drain pulses, and a drain that coincides with the last word.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef enum logic {
        FILLING = 1'b0,
        HOLDING = 1'b1
    } fill_e;

    function automatic int unsigned clog2c(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/ppw_addr_gen.sv
module ppw_addr_gen #(
    parameter int unsigned NUM_PART   = 32,
    parameter int unsigned PART_WORDS = 16,
    parameter int unsigned ADDR_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    import ppw_pkg::*;

    localparam int unsigned PIDX_W = clog2c(NUM_PART);
    localparam int unsigned OFF_W  = clog2c(PART_WORDS);
    localparam logic [PIDX_W-1:0] PIDX_MAX = PIDX_W'(NUM_PART - 1);
    localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(PART_WORDS - 1);

    logic [PIDX_W-1:0] part_idx;
    logic [OFF_W-1:0]  offset;
    logic              sweep_end;

    assign sweep_end = (part_idx == PIDX_MAX);
    assign last      = sweep_end && (offset == OFF_MAX);
    assign addr      = ADDR_W'(part_idx) * ADDR_W'(PART_WORDS) + ADDR_W'(offset);

    always_ff @(posedge clk) begin
        if (rst) begin
            part_idx <= '0;
            offset   <= '0;
        end else if (step) begin
            if (sweep_end) begin
                part_idx <= '0;
                offset   <= (offset == OFF_MAX) ? '0 : offset + 1'b1;
            end else begin
                part_idx <= part_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppw_bank_ctrl.sv
module ppw_bank_ctrl (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            last,
    input  logic            drained,
    output ppw_pkg::bank_e  bank_sel,
    output logic            ready
);
    import ppw_pkg::*;

    fill_e state;
    logic  other_free;

    assign ready = (state == FILLING);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_sel   <= BANK_A;
            state      <= FILLING;
            other_free <= 1'b1;
        end else begin
            case (state)
                FILLING: begin
                    if (accept && last) begin
                        if (other_free || drained) begin
                            bank_sel   <= bank_e'(~bank_sel);
                            other_free <= 1'b0;
                        end else begin
                            state <= HOLDING;
                        end
                    end else if (drained) begin
                        other_free <= 1'b1;
                    end
                end
                HOLDING: begin
                    if (drained) begin
                        bank_sel <= bank_e'(~bank_sel);
                        state    <= FILLING;
                    end
                end
                default: state <= FILLING;
            endcase
        end
    end

endmodule

// File: rtl/ppw_steer.sv
module ppw_steer #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 9
) (
    input  logic                                       accept,
    input  ppw_pkg::bank_e                             bank_sel,
    input  logic [ADDR_W-1:0]                          addr,
    input  logic [DATA_W-1:0]                          data,
    output logic [ppw_pkg::NUM_BANKS-1:0]              wr_en,
    output logic [ppw_pkg::NUM_BANKS-1:0][ADDR_W-1:0]  wr_addr,
    output logic [ppw_pkg::NUM_BANKS-1:0][DATA_W-1:0]  wr_data
);
    import ppw_pkg::*;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        logic hit;
        assign hit        = accept && (int'(bank_sel) == b);
        assign wr_en[b]   = hit;
        assign wr_addr[b] = addr;
        assign wr_data[b] = hit ? data : '0;
    end

endmodule

// File: rtl/ppw_writer.sv
module ppw_writer #(
    parameter  int unsigned DATA_W     = 16,
    parameter  int unsigned NUM_PART   = 32,
    parameter  int unsigned PART_WORDS = 16,
    localparam int unsigned BANK_WORDS = NUM_PART * PART_WORDS,
    localparam int unsigned ADDR_W     = ppw_pkg::clog2c(BANK_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    output logic                         in_ready,
    input  logic                         drained,
    output logic                         bank_sel,
    output logic [1:0]                   wr_en,
    output logic [1:0][ADDR_W-1:0]       wr_addr,
    output logic [1:0][DATA_W-1:0]       wr_data
);
    import ppw_pkg::*;

    logic              accept;
    logic              last;
    logic [ADDR_W-1:0] addr;
    bank_e             bank;

    assign accept   = in_valid && in_ready;
    assign bank_sel = bank;

    ppw_addr_gen #(
        .NUM_PART  (NUM_PART),
        .PART_WORDS(PART_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_addr (
        .clk (clk),
        .rst (rst),
        .step(accept),
        .addr(addr),
        .last(last)
    );

    ppw_bank_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .last    (last),
        .drained (drained),
        .bank_sel(bank),
        .ready   (in_ready)
    );

    ppw_steer #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_steer (
        .accept  (accept),
        .bank_sel(bank),
        .addr    (addr),
        .data    (in_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned BANK_WORDS = 512
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    drained,
    input logic                    bank_sel,
    input logic [1:0]              wr_en,
    input logic [1:0][ADDR_W-1:0]  wr_addr
);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    assert_bank_match_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 2'b00) |-> wr_en[bank_sel]);

    assert_accept_writes_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (wr_en != 2'b00));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |-> (wr_en == 2'b00));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 2'b00) |-> (int'(wr_addr[bank_sel]) < BANK_WORDS));

    assert_no_write_stalled_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |-> (wr_en == 2'b00));

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !drained) |=> !in_ready);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && drained) |=> (in_ready && (bank_sel != $past(bank_sel))));

    assert_swap_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (bank_sel != $past(bank_sel)) |-> $past(drained || (wr_en != 2'b00)));

    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(wr_en != 2'b00));

endmodule

bind ppw_writer ppw_checker #(
    .ADDR_W    (ADDR_W),
    .BANK_WORDS(BANK_WORDS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .drained (drained),
    .bank_sel(bank_sel),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/tb_ppw_writer.sv
module tb_ppw_writer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NP = 32;
    localparam int PW = 8;
    localparam int BW = NP * PW;
    localparam int AW = $clog2(BW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic drained = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready;
    logic bank_sel;
    logic [1:0] wr_en;
    logic [1:0][AW-1:0] wr_addr;
    logic [1:0][DW-1:0] wr_data;

    ppw_writer #(.DATA_W(DW), .NUM_PART(NP), .PART_WORDS(PW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .drained(drained), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    // behavioural reference state
    int m_bank = 0, m_count = 0, m_free = 1, m_hold = 0;
    bit last_acc = 0;
    int next_word = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare, then advance the model at posedge
    task automatic cycle(input bit v, input bit dr);
        int exp_ready, exp_addr, exp_en;
        bit acc;
        in_valid = v; in_data = DW'(16'hA000 + next_word); drained = dr;
        #1;
        exp_ready = m_hold ? 0 : 1;
        acc = v && (exp_ready == 1);
        exp_addr = (m_count % NP) * PW + (m_count / NP);
        exp_en = acc ? (1 << m_bank) : 0;
        check(int'(in_ready) == exp_ready, "R6", "in_ready", int'(in_ready), exp_ready);
        check(int'(bank_sel) == m_bank, "R5", "bank_sel", int'(bank_sel), m_bank);
        if (v) check(int'(wr_en) == exp_en, "R2", "wr_en", int'(wr_en), exp_en);
        else   check(wr_en == 2'b00, "R9", "idle wr_en", int'(wr_en), 0);
        if (acc) begin
            check(int'(wr_addr[m_bank]) == exp_addr, "R3", "wr_addr",
                  int'(wr_addr[m_bank]), exp_addr);
            check(wr_data[m_bank] == in_data, "R4", "wr_data",
                  int'(wr_data[m_bank]), int'(in_data));
        end
        @(posedge clk);
        if (m_hold) begin
            if (dr) begin m_bank ^= 1; m_hold = 0; m_count = 0; end
        end else if (acc) begin
            m_count++;
            if (m_count == BW) begin
                m_count = 0;
                if (m_free || dr) begin m_bank ^= 1; m_free = 0; end
                else m_hold = 1;
            end
        end else if (dr) begin
            m_free = 1;
        end
        last_acc = acc;
        if (acc) next_word++;
        @(negedge clk);
        in_valid = 1'b0; drained = 1'b0;
    endtask

    // push n words with gap idle cycles after each accepted word
    task automatic send(input int n, input int gap);
        int got = 0;
        while (got < n) begin
            cycle(1'b1, 1'b0);
            if (last_acc) begin
                got++;
                for (int g = 0; g < gap; g++) cycle(1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state visible while reset is held
        check(bank_sel == 1'b0, "R1", "bank after reset", int'(bank_sel), 0);
        check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        check(wr_addr[0] == '0, "R1", "first addr", int'(wr_addr[0]), 0);
        rst = 1'b0;

        // R5: first bank fills back-to-back, other bank free from reset
        send(BW, 0);
        check(bank_sel == 1'b1 && in_ready, "R5", "swap without stall",
              int'(bank_sel), 1);

        // R9/R6: second bank with gaps, then stall because nothing drained
        send(BW, 1);
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
        check(in_ready == 1'b0, "R6", "stalled ready", int'(in_ready), 0);

        // R7: drain releases the stall, addressing restarts at 0
        cycle(1'b1, 1'b1);
        #1;
        check(bank_sel == 1'b0 && in_ready, "R7", "release", int'(bank_sel), 0);
        check(wr_addr[0] == '0, "R7", "restart addr", int'(wr_addr[0]), 0);
        @(negedge clk);

        // R8: two early drain pulses give one credit only
        send(10, 0);
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        send(BW - 10, 0);
        check(bank_sel == 1'b1 && in_ready, "R8", "credit used", int'(bank_sel), 1);
        send(BW, 0);
        cycle(1'b1, 1'b0);
        check(in_ready == 1'b0, "R8", "no second credit", int'(in_ready), 0);

        // R5: drain coinciding with the last word swaps at once
        cycle(1'b1, 1'b1);
        send(BW - 1, 2);
        cycle(1'b1, 1'b1);
        check(bank_sel == 1'b1 && in_ready, "R5", "drain on last word",
              int'(bank_sel), 1);
        send(40, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule